// File: doc/BRIEF.md
# ATAPI PIO Burst Read Sequencer

This block is the device side of a packet-command read over a 16-bit programmed-I/O data port. The host writes a transfer byte limit into two byte-wide limit registers and then writes the PACKET command code. The block asks for a 12-byte command packet, which the host sends as six word writes to the data port. When the packet holds a READ(10) opcode, the block streams the requested 2048-byte blocks back one word per host read.

The transfer is cut into bursts. Each burst is no longer than the even-rounded byte limit, and the last one may be shorter. Before every burst the block raises its interrupt and shows a data-request status. A status read acknowledges that interrupt. When the last word has been read, the block raises one more interrupt to mark completion. A limit below two bytes or an unknown opcode ends the command with an abort indication.

The storage medium is stood in for by a pattern source. For absolute block number B and word index W inside the block (0..1023), the word returned is `B[31:16] ^ B[15:0] ^ (W << 6)`.

Top module: `atapi_pio_seq`

## Requirements
- R1: After reset the status byte (register address 7) reads 0x40 (ready bit 6 set; busy bit 7, data-request bit 3 and error bit 0 clear) and `irq` is low.
- R2: A write of 0xA0 to address 7 while idle, with a limit of at least two bytes, moves the block to packet intake: status reads 0x48 and `irq` stays low.
- R3: The packet is six word writes to address 0. Each word carries its even byte in bits 7:0 and its odd byte in bits 15:8. Byte 0 is the opcode, bytes 2..5 are the big-endian LBA, and bytes 7..8 are the big-endian block count. In the cycle after the sixth word, status reads 0xC0 (busy and ready).
- R4: The byte limit is {address 5, address 4}, captured at the PACKET write, with bit 0 ignored. Each burst moves min(limit/2, words remaining) words. Between bursts, status reads 0xC0 for one cycle.
- R5: Each burst begins with `irq` high and status 0x48. A read of address 7 lowers `irq` in the following cycle.
- R6: Reads of address 0 during a burst return the pattern words in order, one word per read strobe, running from block LBA up to LBA+count-1.
- R7: After the final word has been read, `irq` rises once more and status reads 0x40.
- R8: A PACKET write with a limit below 2 aborts at once. `irq` rises, status reads 0x41, and address 1 reads 0x0004 (abort bit 2). Both indications stay set until the next PACKET write.
- R9: A packet whose opcode is not 0x28 aborts after intake, with the same indications as R8.
- R10: A READ(10) with a block count of zero completes at once: `irq` rises and status reads 0x40.
- R11: A read of address 0 outside a burst returns 0x0000 and leaves the status unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe, one access per cycle |
| rd_en | input | 1 | Register read strobe; side effects occur at the clock edge |
| addr | input | 3 | Register address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for `addr`, combinational |
| irq | output | 1 | Interrupt request to the host |

## Verification
The embedded properties check, on every cycle, the handshake edges. They cover intake ending in the busy state, an interrupt at every burst load, interrupt release after a status read, completion after the last word, both abort paths, and counter underflow and burst bounds. The word-step property watches the pattern source. Only the bench scenarios can show the whole-transfer behaviour: that the burst lengths for an odd limit add up to the requested size, that the data crosses block and LBA-fold boundaries in the right order, and that the register values the host sees are correct after each phase.

// File: rtl/atapi_seq_pkg.sv
// Shared encodings for the ATAPI PIO burst sequencer.
// Assumes a byte-wide task-file view with status bit positions fixed by the host driver.
package atapi_seq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PKT  = 2'd1,
        ST_CALC = 2'd2,
        ST_XFER = 2'd3
    } seq_state_e;

    localparam logic [2:0] RA_DATA   = 3'd0;
    localparam logic [2:0] RA_ERROR  = 3'd1;
    localparam logic [2:0] RA_LIM_LO = 3'd4;
    localparam logic [2:0] RA_LIM_HI = 3'd5;
    localparam logic [2:0] RA_STATUS = 3'd7;

    localparam logic [7:0] OP_PACKET = 8'hA0;
    localparam logic [7:0] OP_READ10 = 8'h28;

endpackage

// File: rtl/atapi_pkt_intake.sv
// Command packet intake: counts the word writes of a packet and keeps the
// decoded opcode, LBA and block count.
// Assumes each word carries its even byte in bits 7:0, and that the fields
// sit at byte 0 (opcode), bytes 2..5 (LBA, big-endian) and bytes 7..8 (count, big-endian).
module atapi_pkt_intake #(
    parameter int PKT_WORDS = 6
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clear,
    input  logic        wr_word,
    input  logic [15:0] wdata,
    output logic        last,
    output logic [7:0]  opcode,
    output logic [31:0] lba,
    output logic [15:0] blocks
);
    localparam int CW = $clog2(PKT_WORDS);

    logic [CW-1:0] cnt_q;

    assign last = wr_word && (cnt_q == CW'(PKT_WORDS - 1));

    // Word position counter within the packet.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cnt_q <= '0;
        end else if (wr_word) begin
            cnt_q <= last ? '0 : cnt_q + 1'b1;
        end
    end

    // Capture the fields the sequencer decodes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            opcode <= '0;
            lba    <= '0;
            blocks <= '0;
        end else if (wr_word) begin
            case (cnt_q)
                CW'(0): opcode <= wdata[7:0];
                CW'(1): lba[31:16] <= {wdata[7:0], wdata[15:8]};
                CW'(2): lba[15:0]  <= {wdata[7:0], wdata[15:8]};
                CW'(3): blocks[15:8] <= wdata[15:8];
                CW'(4): blocks[7:0]  <= wdata[7:0];
                default: ;
            endcase
        end
    end

    p_cnt_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < CW'(PKT_WORDS));

endmodule

// File: rtl/atapi_burst_ctrl.sv
// Transfer and burst word counters.
// Assumes the total is loaded before the first burst, and that a burst is
// loaded only while words remain.
module atapi_burst_ctrl #(
    parameter int CNT_W    = 16,
    parameter int BLK_LOG2 = 10,
    parameter int BW_W     = 15,
    localparam int TOT_W   = CNT_W + BLK_LOG2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_total,
    input  logic [CNT_W-1:0] blocks,
    input  logic             load_burst,
    input  logic [BW_W-1:0]  limit_words,
    input  logic             word_rd,
    output logic [TOT_W-1:0] remaining,
    output logic [BW_W-1:0]  burst_left
);
    logic [TOT_W-1:0] limit_wide;

    assign limit_wide = {{(TOT_W - BW_W){1'b0}}, limit_words};

    // Words left in the whole transfer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remaining <= '0;
        end else if (load_total) begin
            remaining <= {blocks, {BLK_LOG2{1'b0}}};
        end else if (word_rd) begin
            remaining <= remaining - 1'b1;
        end
    end

    // Words left in the current burst.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            burst_left <= '0;
        end else if (load_burst) begin
            burst_left <= (remaining < limit_wide) ? BW_W'(remaining) : limit_words;
        end else if (word_rd) begin
            burst_left <= burst_left - 1'b1;
        end
    end

    p_burst_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        load_burst |=> (burst_left != '0) && (burst_left <= $past(limit_words)));

    p_no_underflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        word_rd |-> (remaining != '0) && (burst_left != '0));

endmodule

// File: rtl/atapi_media_src.sv
// Pattern source standing in for the medium: one word per advance, walking the
// words of each block and then the block number.
// Word = lba[31:16] ^ lba[15:0] ^ (word_index << 6).
module atapi_media_src #(
    parameter int BLK_LOG2 = 10
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        load,
    input  logic [31:0] lba_in,
    input  logic        advance,
    output logic [15:0] data_out
);
    logic [31:0]         cur_lba;
    logic [BLK_LOG2-1:0] word_idx;

    // Position within the medium.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_lba  <= '0;
            word_idx <= '0;
        end else if (load) begin
            cur_lba  <= lba_in;
            word_idx <= '0;
        end else if (advance) begin
            if (&word_idx) begin
                word_idx <= '0;
                cur_lba  <= cur_lba + 1'b1;
            end else begin
                word_idx <= word_idx + 1'b1;
            end
        end
    end

    // Pattern word for the current position.
    assign data_out = cur_lba[31:16] ^ cur_lba[15:0] ^ (16'(word_idx) << 6);

    p_word_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && !load && !(&word_idx)) |=>
            (word_idx == $past(word_idx) + 1'b1) && $stable(cur_lba));

endmodule

// File: rtl/atapi_pio_seq.sv
// ATAPI PIO burst read sequencer (top level).
// Holds the register view, the command phase machine and the interrupt.
// Assumes at most one register access per cycle. Read side effects take
// place at the clock edge of the read strobe.
module atapi_pio_seq
    import atapi_seq_pkg::*;
#(
    parameter int BLK_LOG2  = 10,
    parameter int PKT_WORDS = 6
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic        rd_en,
    input  logic [2:0]  addr,
    input  logic [15:0] wdata,
    output logic [15:0] rdata,
    output logic        irq
);
    localparam int CNT_W = 16;
    localparam int LIM_W = 16;
    localparam int BW_W  = LIM_W - 1;
    localparam int TOT_W = CNT_W + BLK_LOG2;

    seq_state_e       state_q;
    logic             err_q;
    logic [7:0]       lim_lo_q;
    logic [7:0]       lim_hi_q;
    logic [BW_W-1:0]  limit_words_q;
    logic [BW_W-1:0]  lim_words_new;

    logic             cmd_wr, data_wr, data_rd, stat_rd, op_ok;
    logic             load_burst;
    logic             pkt_last;
    logic [7:0]       pkt_opcode;
    logic [31:0]      pkt_lba;
    logic [15:0]      pkt_blocks;
    logic [TOT_W-1:0] remaining;
    logic [BW_W-1:0]  burst_left;
    logic [15:0]      media_word;
    logic [7:0]       status;

    assign lim_words_new = {lim_hi_q, lim_lo_q[7:1]};
    assign cmd_wr  = wr_en && (addr == RA_STATUS) && (wdata[7:0] == OP_PACKET)
                     && (state_q == ST_IDLE);
    assign data_wr = wr_en && (addr == RA_DATA) && (state_q == ST_PKT);
    assign data_rd = rd_en && (addr == RA_DATA) && (state_q == ST_XFER);
    assign stat_rd = rd_en && (addr == RA_STATUS);
    assign op_ok   = (pkt_opcode == OP_READ10);
    assign load_burst = (state_q == ST_CALC) && op_ok && (remaining != '0);

    atapi_pkt_intake #(.PKT_WORDS(PKT_WORDS)) u_intake (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (cmd_wr),
        .wr_word (data_wr),
        .wdata   (wdata),
        .last    (pkt_last),
        .opcode  (pkt_opcode),
        .lba     (pkt_lba),
        .blocks  (pkt_blocks)
    );

    atapi_burst_ctrl #(.CNT_W(CNT_W), .BLK_LOG2(BLK_LOG2), .BW_W(BW_W)) u_burst (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_total  (pkt_last),
        .blocks      (pkt_blocks),
        .load_burst  (load_burst),
        .limit_words (limit_words_q),
        .word_rd     (data_rd),
        .remaining   (remaining),
        .burst_left  (burst_left)
    );

    atapi_media_src #(.BLK_LOG2(BLK_LOG2)) u_media (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (pkt_last),
        .lba_in   (pkt_lba),
        .advance  (data_rd),
        .data_out (media_word)
    );

    // Byte limit registers written by the host.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lim_lo_q <= '0;
            lim_hi_q <= '0;
        end else if (wr_en && (addr == RA_LIM_LO)) begin
            lim_lo_q <= wdata[7:0];
        end else if (wr_en && (addr == RA_LIM_HI)) begin
            lim_hi_q <= wdata[7:0];
        end
    end

    // Command phase machine, abort flag and interrupt.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q       <= ST_IDLE;
            err_q         <= 1'b0;
            irq           <= 1'b0;
            limit_words_q <= '0;
        end else begin
            if (stat_rd) irq <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (cmd_wr) begin
                        irq   <= 1'b0;
                        err_q <= 1'b0;
                        if (lim_words_new == '0) begin
                            err_q <= 1'b1;
                            irq   <= 1'b1;
                        end else begin
                            limit_words_q <= lim_words_new;
                            state_q       <= ST_PKT;
                        end
                    end
                end
                ST_PKT: begin
                    if (pkt_last) state_q <= ST_CALC;
                end
                ST_CALC: begin
                    irq <= 1'b1;
                    if (!op_ok) begin
                        err_q   <= 1'b1;
                        state_q <= ST_IDLE;
                    end else if (remaining == '0) begin
                        state_q <= ST_IDLE;
                    end else begin
                        state_q <= ST_XFER;
                    end
                end
                ST_XFER: begin
                    if (data_rd) begin
                        if (remaining == TOT_W'(1)) begin
                            irq     <= 1'b1;
                            state_q <= ST_IDLE;
                        end else if (burst_left == BW_W'(1)) begin
                            state_q <= ST_CALC;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Status byte: busy 7, ready 6, data request 3, error 0.
    assign status = {(state_q == ST_CALC), 1'b1, 2'b00,
                     (state_q == ST_PKT) || (state_q == ST_XFER), 2'b00, err_q};

    // Register read mux.
    always_comb begin
        case (addr)
            RA_DATA:   rdata = (state_q == ST_XFER) ? media_word : 16'h0000;
            RA_ERROR:  rdata = {13'd0, err_q, 2'b00};
            RA_LIM_LO: rdata = {8'h00, lim_lo_q};
            RA_LIM_HI: rdata = {8'h00, lim_hi_q};
            RA_STATUS: rdata = {8'h00, status};
            default:   rdata = 16'h0000;
        endcase
    end

    p_pkt_to_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && pkt_last) |=> (state_q == ST_CALC));

    p_burst_irq_r5: assert property (@(posedge clk) disable iff (!rst_n)
        load_burst |=> (state_q == ST_XFER) && irq);

    p_irq_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_XFER) && stat_rd) |=> !irq);

    p_completion_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (data_rd && (remaining == TOT_W'(1))) |=> (state_q == ST_IDLE) && irq && !err_q);

    p_limit_abort_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && (lim_words_new == '0)) |=> (state_q == ST_IDLE) && irq && err_q);

    p_opcode_abort_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_CALC) && !op_ok) |=> (state_q == ST_IDLE) && irq && err_q);

endmodule

// File: tb/atapi_pio_seq_bench.sv
// Scoreboard bench: the driver pushes expected data words into a queue, and a
// monitor pops and compares them as the design returns them.
module atapi_pio_seq_bench;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en, rd_en;
    logic [2:0]  addr;
    logic [15:0] wdata;
    logic [15:0] rdata;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    logic [15:0] exp_q [$];
    logic [15:0] obs_word;
    event        obs_ev;

    always #2 clk = ~clk;

    atapi_pio_seq u_atapi_pio_seq (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (wr_en),
        .rd_en (rd_en),
        .addr  (addr),
        .wdata (wdata),
        .rdata (rdata),
        .irq   (irq)
    );

    task automatic check(input string req, input logic [31:0] act,
                         input logic [31:0] exp, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] pattern(input logic [31:0] blk, input int w);
        logic [15:0] wi;
        wi = 16'(w);
        return blk[31:16] ^ blk[15:0] ^ (wi << 6);
    endfunction

    task automatic bus_wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic bus_rd(input logic [2:0] a, output logic [15:0] d);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        #1 d = rdata;
        @(posedge clk); #1;
        rd_en = 1'b0;
    endtask

    task automatic read_word();
        logic [15:0] v;
        bus_rd(3'd0, v);
        obs_word = v;
        -> obs_ev;
    endtask

    task automatic wait_irq(output bit got);
        got = 1'b0;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk); #1;
            if (irq) begin
                got = 1'b1;
                break;
            end
        end
    endtask

    task automatic program_limit(input int lim);
        bus_wr(3'd4, 16'(lim & 8'hFF));
        bus_wr(3'd5, 16'((lim >> 8) & 8'hFF));
    endtask

    task automatic send_packet(input logic [7:0] op, input logic [31:0] lba,
                               input logic [15:0] cnt);
        bus_wr(3'd0, {8'h00, op});
        bus_wr(3'd0, {lba[23:16], lba[31:24]});
        bus_wr(3'd0, {lba[7:0], lba[15:8]});
        bus_wr(3'd0, {cnt[15:8], 8'h00});
        bus_wr(3'd0, {8'h00, cnt[7:0]});
        bus_wr(3'd0, 16'h0000);
    endtask

    // Scoreboard monitor: compares each returned word with the oldest expected one.
    initial begin
        forever begin
            @(obs_ev);
            if (exp_q.size() == 0) begin
                check("R6", {16'h0, obs_word}, 32'hFFFF_FFFF, "unexpected data word");
            end else begin
                check("R6", {16'h0, obs_word}, {16'h0, exp_q.pop_front()}, "data word");
            end
        end
    end

    // Full READ(10) transfer with burst handshakes.
    task automatic run_read(input logic [31:0] lba, input int cnt, input int lim);
        logic [15:0] s;
        bit got;
        int limw, total, done, burst;
        limw  = lim / 2;
        total = cnt * 1024;
        program_limit(lim);
        bus_wr(3'd7, 16'h00A0);
        bus_rd(3'd7, s);
        check("R2", {16'h0, s}, 32'h48, "status in packet phase");
        check("R2", {31'h0, irq}, 32'h0, "irq in packet phase");
        send_packet(8'h28, lba, 16'(cnt));
        bus_rd(3'd7, s);
        check("R3", {16'h0, s}, 32'hC0, "status after packet");
        for (int k = 0; k < total; k++) exp_q.push_back(pattern(lba + 32'(k / 1024), k % 1024));
        done = 0;
        while (done < total) begin
            wait_irq(got);
            check("R5", {31'h0, got}, 32'h1, "irq at burst start");
            bus_rd(3'd7, s);
            check("R5", {16'h0, s}, 32'h48, "status at burst start");
            check("R5", {31'h0, irq}, 32'h0, "irq after status read");
            burst = (total - done < limw) ? total - done : limw;
            for (int j = 0; j < burst; j++) read_word();
            done += burst;
            if (done < total) begin
                bus_rd(3'd7, s);
                check("R4", {16'h0, s}, 32'hC0, "status at burst boundary");
            end
        end
        check("R7", {31'h0, irq}, 32'h1, "completion irq");
        bus_rd(3'd7, s);
        check("R7", {16'h0, s}, 32'h40, "final status");
        check("R7", {31'h0, irq}, 32'h0, "irq after final status read");
        check("R6", 32'(exp_q.size()), 32'h0, "words left unread");
    endtask

    task automatic report();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    initial begin
        #(4 * 100000);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=done");
            report();
            $finish;
        end
    end

    initial begin
        logic [15:0] s;
        bit got;
        wr_en = 1'b0; rd_en = 1'b0; addr = 3'd0; wdata = 16'h0;
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        bus_rd(3'd7, s);
        check("R1", {16'h0, s}, 32'h40, "status after reset");
        check("R1", {31'h0, irq}, 32'h0, "irq after reset");

        // R11: data read outside a burst
        bus_rd(3'd0, s);
        check("R11", {16'h0, s}, 32'h0, "idle data read");
        bus_rd(3'd7, s);
        check("R11", {16'h0, s}, 32'h40, "status after idle data read");

        // R4 R6: single block, limit larger than the transfer
        run_read(32'd3, 1, 5120);
        // R4 R6: odd limit, several bursts, LBA fold crossing
        run_read(32'h0000_FFFF, 3, 1001);

        // R8: limit below two bytes
        program_limit(1);
        bus_wr(3'd7, 16'h00A0);
        check("R8", {31'h0, irq}, 32'h1, "irq on limit abort");
        bus_rd(3'd1, s);
        check("R8", {16'h0, s}, 32'h4, "error register on limit abort");
        bus_rd(3'd7, s);
        check("R8", {16'h0, s}, 32'h41, "status on limit abort");

        // R9: unknown opcode
        program_limit(5120);
        bus_wr(3'd7, 16'h00A0);
        bus_rd(3'd7, s);
        check("R8", {16'h0, s}, 32'h48, "error cleared by new PACKET");
        send_packet(8'h12, 32'd0, 16'd1);
        wait_irq(got);
        check("R9", {31'h0, got}, 32'h1, "irq on opcode abort");
        bus_rd(3'd1, s);
        check("R9", {16'h0, s}, 32'h4, "error register on opcode abort");
        bus_rd(3'd7, s);
        check("R9", {16'h0, s}, 32'h41, "status on opcode abort");

        // R10: zero block count
        bus_wr(3'd7, 16'h00A0);
        send_packet(8'h28, 32'd5, 16'd0);
        wait_irq(got);
        check("R10", {31'h0, got}, 32'h1, "irq on empty transfer");
        bus_rd(3'd7, s);
        check("R10", {16'h0, s}, 32'h40, "status on empty transfer");
        bus_rd(3'd0, s);
        check("R11", {16'h0, s}, 32'h0, "data read after empty transfer");

        finished = 1'b1;
        report();
        $finish;
    end

endmodule